// File: doc/BRIEF.md
# MMC device state controller

This block follows the operating state of a MultiMediaCard-style memory device, driven by host commands that have already been parsed. Each command arrives as a 6-bit index and a 32-bit argument with a one-cycle valid strobe. A separate one-cycle strobe carries a newly assigned relative card address (RCA). A third strobe tells the block that a data block has finished. From these inputs the controller tracks the device phase: idle, identification, standby, transfer, block read and block receive. It also holds the assigned RCA, the active command set and the high-speed timing byte.

The block produces a one-cycle response-enable pulse for every command it accepts. The response logic uses this pulse to decide whether to answer. The block also produces a high-speed-allowed flag, which the clock control uses before it raises the bus clock above 20 MHz. The states gate data transfer behind RCA assignment and behind a select command that carries the device's own address. A switch command changes the command set and the timing byte, and a software reset restores both.

Top module: `mmc_state_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in Idle, with `rca_valid`, `cmd_set`, `hs_timing`, `hs_allowed` and `rsp_en` all 0 and `rca_o` cleared. The `dev_state` encoding is Idle=0, Identification=1, Standby=2, Transfer=3, Read=4 and Receive=5.
- R2: In Idle, index 1 is answered (`rsp_en` is high in the cycle after the command) and the state does not change. Index 2 is answered and moves the state to Identification.
- R3: A `rca_assign` strobe in Identification stores `rca_value` in `rca_o`, sets `rca_valid` and moves the state to Standby. In any other state the strobe is ignored. A command on the same cycle takes priority over the strobe.
- R4: While `rca_valid` is 1, indices 1 and 2 get no response and do not change the state.
- R5: In Standby, index 7 with `cmd_arg[31:16]` equal to the stored RCA is answered and moves the state to Transfer. The same command with a different address does nothing. Transfer and the data states are only reachable with `rca_valid` set.
- R6: In Transfer, index 7 with a non-matching address moves the state back to Standby with no response. A matching index 7 in Transfer is answered and the state does not change. In any other state, index 7 is ignored.
- R7: Index 9 is answered only in Standby with a matching address, and it leaves the state unchanged. Anywhere else it gets no response.
- R8: Index 6 is accepted only in Transfer, where it is answered. When the access field `cmd_arg[25:24]` is 00, `cmd_set` takes the value of `cmd_arg[2:0]`. Outside Transfer, index 6 has no effect.
- R9: An accepted index 6 with access field 11 and byte index `cmd_arg[23:16]` equal to 185 writes `cmd_arg[15:8]` to `hs_timing`. A different byte index leaves the byte unchanged. `hs_allowed` is 1 exactly while `hs_timing` is 0x01.
- R10: In Transfer, index 17 (single read) moves the state to Read and index 24 (single write) moves it to Receive, each with a response. One `blk_done` strobe then returns the state to Transfer.
- R11: Index 18 (multi read) enters Read and index 25 (multi write) enters Receive, each with a response. The state stays there across `blk_done` strobes until index 12 returns it to Transfer, which is answered.
- R12: Index 0 from any state goes to Idle with no response. It clears `rca_valid`, `cmd_set` and `hs_timing` (and so `hs_allowed`), which lets identification run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a parsed command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rca_assign | input | 1 | One-cycle strobe that assigns an RCA |
| rca_value | input | 16 | RCA carried by `rca_assign` |
| blk_done | input | 1 | One-cycle strobe at the end of a data block |
| dev_state | output | 3 | Device state, encoded as in R1 |
| rca_o | output | 16 | Stored RCA |
| rca_valid | output | 1 | An RCA is held |
| cmd_set | output | 3 | Active command set |
| hs_timing | output | 8 | High-speed timing byte |
| hs_allowed | output | 1 | Clock above 20 MHz is permitted |
| rsp_en | output | 1 | One-cycle pulse for each accepted command |

## Verification
The assertions check several rules on every cycle:
- any state from Standby onward implies a held RCA;
- Transfer is entered from Standby only through a select command;
- index 0 always lands in Idle and is never answered;
- identification commands stay silent once an address is held;
- the timing byte changes only through an accepted switch or a reset;
- `hs_allowed` agrees with the timing byte.

Only the bench scenarios can show the address comparison against a real stored value, the difference between single-block and multiple-block endings, and the effect of each switch access code. The same holds for the full walk from Idle through identification, selection, data and deselection.

// File: rtl/mmc_sc_pkg.sv
package mmc_sc_pkg;
  localparam int CMD_IDX_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_IDENT = 3'd1,
    ST_STBY  = 3'd2,
    ST_TRAN  = 3'd3,
    ST_READ  = 3'd4,
    ST_WRITE = 3'd5
  } dev_state_e;

  localparam logic [CMD_IDX_W-1:0] CMD_RESET  = 6'd0;
  localparam logic [CMD_IDX_W-1:0] CMD_OPCOND = 6'd1;
  localparam logic [CMD_IDX_W-1:0] CMD_GETID  = 6'd2;
  localparam logic [CMD_IDX_W-1:0] CMD_SWITCH = 6'd6;
  localparam logic [CMD_IDX_W-1:0] CMD_SELECT = 6'd7;
  localparam logic [CMD_IDX_W-1:0] CMD_GETCSD = 6'd9;
  localparam logic [CMD_IDX_W-1:0] CMD_STOP   = 6'd12;
  localparam logic [CMD_IDX_W-1:0] CMD_RD1    = 6'd17;
  localparam logic [CMD_IDX_W-1:0] CMD_RDN    = 6'd18;
  localparam logic [CMD_IDX_W-1:0] CMD_WR1    = 6'd24;
  localparam logic [CMD_IDX_W-1:0] CMD_WRN    = 6'd25;

  localparam logic [1:0] ACC_CSET  = 2'b00;
  localparam logic [1:0] ACC_WBYTE = 2'b11;
endpackage

// File: rtl/mmc_sc_fsm.sv
module mmc_sc_fsm
  import mmc_sc_pkg::*;
#(
  parameter int RCA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [CMD_IDX_W-1:0] cmd_index,
  input  logic [RCA_W-1:0]     arg_rca,
  input  logic                 rca_assign,
  input  logic [RCA_W-1:0]     rca_value,
  input  logic                 blk_done,
  output dev_state_e           state_o,
  output logic [RCA_W-1:0]     rca_o,
  output logic                 rca_set_o,
  output logic                 accept_o,
  output logic                 switch_o,
  output logic                 soft_rst_o
);
  dev_state_e       nxt_state;
  logic [RCA_W-1:0] nxt_rca;
  logic             nxt_set, multi_q, nxt_multi, match, in_data;

  assign match   = rca_set_o && (arg_rca == rca_o);
  assign in_data = (state_o == ST_READ) || (state_o == ST_WRITE);

  always_comb begin
    nxt_state  = state_o;
    nxt_rca    = rca_o;
    nxt_set    = rca_set_o;
    nxt_multi  = multi_q;
    accept_o   = 1'b0;
    switch_o   = 1'b0;
    soft_rst_o = 1'b0;
    if (cmd_valid) begin
      case (cmd_index)
        CMD_RESET: begin
          nxt_state  = ST_IDLE;
          nxt_rca    = '0;
          nxt_set    = 1'b0;
          nxt_multi  = 1'b0;
          soft_rst_o = 1'b1;
        end
        CMD_OPCOND: if (state_o == ST_IDLE && !rca_set_o) accept_o = 1'b1;
        CMD_GETID: if (state_o == ST_IDLE && !rca_set_o) begin
          accept_o  = 1'b1;
          nxt_state = ST_IDENT;
        end
        CMD_SELECT: begin
          if (state_o == ST_STBY && match) begin
            accept_o  = 1'b1;
            nxt_state = ST_TRAN;
          end else if (state_o == ST_TRAN) begin
            if (match) accept_o = 1'b1;
            else nxt_state = ST_STBY;
          end
        end
        CMD_GETCSD: if (state_o == ST_STBY && match) accept_o = 1'b1;
        CMD_SWITCH: if (state_o == ST_TRAN) begin
          accept_o = 1'b1;
          switch_o = 1'b1;
        end
        CMD_RD1, CMD_RDN: if (state_o == ST_TRAN) begin
          accept_o  = 1'b1;
          nxt_state = ST_READ;
          nxt_multi = (cmd_index == CMD_RDN);
        end
        CMD_WR1, CMD_WRN: if (state_o == ST_TRAN) begin
          accept_o  = 1'b1;
          nxt_state = ST_WRITE;
          nxt_multi = (cmd_index == CMD_WRN);
        end
        CMD_STOP: if (in_data) begin
          accept_o  = 1'b1;
          nxt_state = ST_TRAN;
          nxt_multi = 1'b0;
        end
        default: ;
      endcase
    end else if (rca_assign && state_o == ST_IDENT) begin
      nxt_rca   = rca_value;
      nxt_set   = 1'b1;
      nxt_state = ST_STBY;
    end else if (blk_done && in_data && !multi_q) begin
      nxt_state = ST_TRAN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o   <= ST_IDLE;
      rca_o     <= '0;
      rca_set_o <= 1'b0;
      multi_q   <= 1'b0;
    end else begin
      state_o   <= nxt_state;
      rca_o     <= nxt_rca;
      rca_set_o <= nxt_set;
      multi_q   <= nxt_multi;
    end
  end

  p_rca_before_xfer_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o >= ST_STBY) |-> rca_set_o);

  p_tran_by_select_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == ST_STBY && state_o == ST_TRAN) |->
      ($past(cmd_valid) && $past(cmd_index) == CMD_SELECT));

  p_reset_to_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == CMD_RESET) |=> (state_o == ST_IDLE && !rca_set_o));
endmodule

// File: rtl/mmc_sc_ext.sv
module mmc_sc_ext
  import mmc_sc_pkg::*;
#(
  parameter int         CSET_W = 3,
  parameter logic [7:0] HS_IDX = 8'd185
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              clr,
  input  logic [25:0]       arg,
  output logic [CSET_W-1:0] cset_o,
  output logic [7:0]        hs_o,
  output logic              hs_ok_o
);
  logic [CSET_W-1:0] nxt_cset;
  logic [7:0]        nxt_hs;

  always_comb begin
    nxt_cset = cset_o;
    nxt_hs   = hs_o;
    if (clr) begin
      nxt_cset = '0;
      nxt_hs   = 8'h00;
    end else if (wr) begin
      if (arg[25:24] == ACC_CSET)
        nxt_cset = arg[CSET_W-1:0];
      else if (arg[25:24] == ACC_WBYTE && arg[23:16] == HS_IDX)
        nxt_hs = arg[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cset_o  <= '0;
      hs_o    <= 8'h00;
      hs_ok_o <= 1'b0;
    end else begin
      cset_o  <= nxt_cset;
      hs_o    <= nxt_hs;
      hs_ok_o <= (nxt_hs == 8'h01);
    end
  end

  p_hs_flag_agrees_r9: assert property (@(posedge clk) disable iff (rst)
    hs_ok_o == (hs_o == 8'h01));

  p_hs_only_by_switch_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(hs_o) |-> ($past(wr) || $past(clr)));
endmodule

// File: rtl/mmc_sc_rsp.sv
module mmc_sc_rsp (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic rsp_en_o
);
  always_ff @(posedge clk) begin
    if (rst) rsp_en_o <= 1'b0;
    else     rsp_en_o <= accept;
  end
endmodule

// File: rtl/mmc_state_ctrl.sv
module mmc_state_ctrl
  import mmc_sc_pkg::*;
#(
  parameter int         RCA_W  = 16,
  parameter int         CSET_W = 3,
  parameter logic [7:0] HS_IDX = 8'd185
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_index,
  input  logic [31:0]       cmd_arg,
  input  logic              rca_assign,
  input  logic [RCA_W-1:0]  rca_value,
  input  logic              blk_done,
  output logic [2:0]        dev_state,
  output logic [RCA_W-1:0]  rca_o,
  output logic              rca_valid,
  output logic [CSET_W-1:0] cmd_set,
  output logic [7:0]        hs_timing,
  output logic              hs_allowed,
  output logic              rsp_en
);
  dev_state_e st;
  logic       accept, sw, soft_rst;

  mmc_sc_fsm #(.RCA_W(RCA_W)) u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .arg_rca(cmd_arg[31 -: RCA_W]), .rca_assign(rca_assign),
    .rca_value(rca_value), .blk_done(blk_done), .state_o(st),
    .rca_o(rca_o), .rca_set_o(rca_valid), .accept_o(accept),
    .switch_o(sw), .soft_rst_o(soft_rst)
  );

  mmc_sc_ext #(.CSET_W(CSET_W), .HS_IDX(HS_IDX)) u_ext (
    .clk(clk), .rst(rst), .wr(sw), .clr(soft_rst), .arg(cmd_arg[25:0]),
    .cset_o(cmd_set), .hs_o(hs_timing), .hs_ok_o(hs_allowed)
  );

  mmc_sc_rsp u_rsp (.clk(clk), .rst(rst), .accept(accept), .rsp_en_o(rsp_en));

  assign dev_state = st;

  p_ident_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rca_valid && (cmd_index == CMD_OPCOND || cmd_index == CMD_GETID))
      |=> (!rsp_en && $stable(dev_state)));

  p_reset_silent_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == CMD_RESET) |=> (!rsp_en && hs_timing == 8'h00));
endmodule

// File: tb/mmc_state_ctrl_test.sv
`timescale 1ns/1ps
module mmc_state_ctrl_test;
  logic        clk = 1'b0;
  logic        rst, cmd_valid, rca_assign, blk_done;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [15:0] rca_value;
  logic [2:0]  dev_state, cmd_set;
  logic [15:0] rca_o;
  logic        rca_valid, hs_allowed, rsp_en;
  logic [7:0]  hs_timing;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmc_state_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .rca_assign(rca_assign), .rca_value(rca_value),
    .blk_done(blk_done), .dev_state(dev_state), .rca_o(rca_o),
    .rca_valid(rca_valid), .cmd_set(cmd_set), .hs_timing(hs_timing),
    .hs_allowed(hs_allowed), .rsp_en(rsp_en)
  );

  // {req, op(0 cmd,1 rca assign,2 block done), index, arg, state, rsp, cmd_set, hs_allowed}
  localparam int NV = 37;
  localparam logic [51:0] VEC [NV] = '{
    {4'd7,  2'd0, 6'd9,  32'h00000000, 3'd0, 1'b0, 3'd0, 1'b0}, // R7 idle
    {4'd2,  2'd0, 6'd1,  32'h00000000, 3'd0, 1'b1, 3'd0, 1'b0}, // R2
    {4'd6,  2'd0, 6'd7,  32'h12340000, 3'd0, 1'b0, 3'd0, 1'b0}, // R6 idle
    {4'd2,  2'd0, 6'd2,  32'h00000000, 3'd1, 1'b1, 3'd0, 1'b0}, // R2
    {4'd3,  2'd1, 6'd0,  32'h12340000, 3'd2, 1'b0, 3'd0, 1'b0}, // R3
    {4'd4,  2'd0, 6'd2,  32'h00000000, 3'd2, 1'b0, 3'd0, 1'b0}, // R4
    {4'd4,  2'd0, 6'd1,  32'h00000000, 3'd2, 1'b0, 3'd0, 1'b0}, // R4
    {4'd7,  2'd0, 6'd9,  32'h55550000, 3'd2, 1'b0, 3'd0, 1'b0}, // R7 mismatch
    {4'd7,  2'd0, 6'd9,  32'h12340000, 3'd2, 1'b1, 3'd0, 1'b0}, // R7
    {4'd5,  2'd0, 6'd7,  32'h55550000, 3'd2, 1'b0, 3'd0, 1'b0}, // R5 mismatch
    {4'd5,  2'd0, 6'd7,  32'h12340000, 3'd3, 1'b1, 3'd0, 1'b0}, // R5
    {4'd7,  2'd0, 6'd9,  32'h12340000, 3'd3, 1'b0, 3'd0, 1'b0}, // R7 transfer
    {4'd3,  2'd1, 6'd0,  32'h77770000, 3'd3, 1'b0, 3'd0, 1'b0}, // R3 ignored
    {4'd10, 2'd0, 6'd17, 32'h00000000, 3'd4, 1'b1, 3'd0, 1'b0}, // R10
    {4'd10, 2'd2, 6'd0,  32'h00000000, 3'd3, 1'b0, 3'd0, 1'b0}, // R10
    {4'd10, 2'd0, 6'd24, 32'h00000000, 3'd5, 1'b1, 3'd0, 1'b0}, // R10
    {4'd10, 2'd2, 6'd0,  32'h00000000, 3'd3, 1'b0, 3'd0, 1'b0}, // R10
    {4'd11, 2'd0, 6'd18, 32'h00000000, 3'd4, 1'b1, 3'd0, 1'b0}, // R11
    {4'd11, 2'd2, 6'd0,  32'h00000000, 3'd4, 1'b0, 3'd0, 1'b0}, // R11
    {4'd11, 2'd2, 6'd0,  32'h00000000, 3'd4, 1'b0, 3'd0, 1'b0}, // R11
    {4'd6,  2'd0, 6'd7,  32'h12340000, 3'd4, 1'b0, 3'd0, 1'b0}, // R6 data state
    {4'd11, 2'd0, 6'd12, 32'h00000000, 3'd3, 1'b1, 3'd0, 1'b0}, // R11
    {4'd11, 2'd0, 6'd25, 32'h00000000, 3'd5, 1'b1, 3'd0, 1'b0}, // R11
    {4'd11, 2'd2, 6'd0,  32'h00000000, 3'd5, 1'b0, 3'd0, 1'b0}, // R11
    {4'd11, 2'd0, 6'd12, 32'h00000000, 3'd3, 1'b1, 3'd0, 1'b0}, // R11
    {4'd6,  2'd0, 6'd7,  32'h55550000, 3'd2, 1'b0, 3'd0, 1'b0}, // R6 deselect
    {4'd6,  2'd0, 6'd7,  32'h12340000, 3'd3, 1'b1, 3'd0, 1'b0}, // R6 reselect
    {4'd8,  2'd0, 6'd6,  32'h00000002, 3'd3, 1'b1, 3'd2, 1'b0}, // R8
    {4'd9,  2'd0, 6'd6,  32'h03B90100, 3'd3, 1'b1, 3'd2, 1'b1}, // R9
    {4'd9,  2'd0, 6'd6,  32'h03B80200, 3'd3, 1'b1, 3'd2, 1'b1}, // R9 other index
    {4'd9,  2'd0, 6'd6,  32'h03B90200, 3'd3, 1'b1, 3'd2, 1'b0}, // R9 value 2
    {4'd9,  2'd0, 6'd6,  32'h03B90100, 3'd3, 1'b1, 3'd2, 1'b1}, // R9
    {4'd6,  2'd0, 6'd7,  32'h55550000, 3'd2, 1'b0, 3'd2, 1'b1}, // R6
    {4'd8,  2'd0, 6'd6,  32'h00000005, 3'd2, 1'b0, 3'd2, 1'b1}, // R8 standby
    {4'd12, 2'd0, 6'd0,  32'h00000000, 3'd0, 1'b0, 3'd0, 1'b0}, // R12
    {4'd12, 2'd0, 6'd2,  32'h00000000, 3'd1, 1'b1, 3'd0, 1'b0}, // R12 ident again
    {4'd12, 2'd0, 6'd0,  32'h00000000, 3'd0, 1'b0, 3'd0, 1'b0}  // R12
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid  = (op == 2'd0);
    rca_assign = (op == 2'd1);
    blk_done   = (op == 2'd2);
    cmd_index  = idx;
    cmd_arg    = arg;
    rca_value  = arg[31:16];
    @(negedge clk);
    cmd_valid  = 1'b0;
    rca_assign = 1'b0;
    blk_done   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; rca_assign = 1'b0; blk_done = 1'b0;
    cmd_index = '0; cmd_arg = '0; rca_value = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'(dev_state), 32'd0);
    check("R1 reset rca_valid", 32'(rca_valid), 32'd0);
    check("R1 reset cmd_set", 32'(cmd_set), 32'd0);
    check("R1 reset hs_timing", 32'(hs_timing), 32'd0);
    check("R1 reset hs_allowed", 32'(hs_allowed), 32'd0);
    check("R1 reset rsp_en", 32'(rsp_en), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      step(v[47:46], v[45:40], v[39:8]);
      check($sformatf("R%0d vec %0d state", v[51:48], i), 32'(dev_state), 32'(v[7:5]));
      check($sformatf("R%0d vec %0d rsp_en", v[51:48], i), 32'(rsp_en), 32'(v[4]));
      check($sformatf("R%0d vec %0d cmd_set", v[51:48], i), 32'(cmd_set), 32'(v[3:1]));
      check($sformatf("R%0d vec %0d hs_allowed", v[51:48], i), 32'(hs_allowed), 32'(v[0]));
    end

    // R3: stored address value
    step(2'd0, 6'd2, 32'h0);
    step(2'd1, 6'd0, 32'hBEEF0000);
    check("R3 rca_o", 32'(rca_o), 32'h0000BEEF);
    check("R3 rca_valid", 32'(rca_valid), 32'd1);
    check("R3 state", 32'(dev_state), 32'd2);

    // R12: software reset from a data state clears everything
    step(2'd0, 6'd7, 32'hBEEF0000);
    step(2'd0, 6'd6, 32'h03B90100);
    check("R9 hs_timing written", 32'(hs_timing), 32'h01);
    step(2'd0, 6'd18, 32'h0);
    check("R11 multi read entered", 32'(dev_state), 32'd4);
    step(2'd0, 6'd0, 32'h0);
    check("R12 state idle", 32'(dev_state), 32'd0);
    check("R12 rca_valid cleared", 32'(rca_valid), 32'd0);
    check("R12 hs_timing cleared", 32'(hs_timing), 32'h00);
    check("R12 hs_allowed cleared", 32'(hs_allowed), 32'd0);
    check("R12 no response", 32'(rsp_en), 32'd0);

    // R1: synchronous reset in the middle of operation
    step(2'd0, 6'd2, 32'h0);
    step(2'd1, 6'd0, 32'h11110000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid reset state", 32'(dev_state), 32'd0);
    check("R1 mid reset rca_valid", 32'(rca_valid), 32'd0);
    check("R1 mid reset rca_o", 32'(rca_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule